// File: doc/BRIEF.md
# Paper Tape Reader Interface

This block is the bus-side interface card for an 8-bit paper tape reader attached to a minicomputer I/O bus. The CPU issues decoded I/O commands that carry a 6-bit device field, a 3-bit operation code and a hold/clear modifier bit. The card reacts only when the device field matches its configured number. Setting control starts a reader cycle through a command flip-flop. The reader answers with a one-cycle byte-ready strobe and eight data bits. That strobe ends the reader cycle, raises the flag and captures the byte in a holding buffer.

The CPU polls the flag with the two skip operations. It reads the byte with load, or ORs it into bus data with merge. It clears the flag with the hold/clear modifier, which it may attach to any operation. The service-request output tracks the flag for a DMA engine. The skip decision and the read data are combinational, so the CPU sees them in the same cycle as its command. All flip-flop changes take effect at the clock edge that ends that cycle.

Top module: `tape_rdr_if`

## Requirements
- R1: After reset, ctl_o and rdr_run are 0, flag_o, fbf_o and srq_o are 1, rdr_start is 0, and a load returns 0.
- R2: A matched op 1 (set control) sets ctl_o and rdr_run at the next edge. rdr_start is high for exactly the one cycle after rdr_run rises, and is not repeated when set control arrives while rdr_run is already 1.
- R3: A matched op 2 (clear control) clears both ctl_o and rdr_run at the next edge.
- R4: rdr_ready while rdr_run is 1 clears rdr_run, sets flag_o and fbf_o, and stores rdr_data in the buffer at the next edge.
- R5: rdr_ready while rdr_run is 0 is ignored: the flag and the buffer keep their values.
- R6: A matched op 6 (load) returns the buffer zero-extended in io_dout[7:0]. A matched op 7 (merge) returns io_din OR the buffer. Every other operation returns io_din unchanged.
- R7: A matched op 5 asserts io_skip when flag_o is 1. A matched op 4 asserts io_skip when flag_o is 0. No other operation asserts io_skip.
- R8: A matched op 3 with io_hc = 0 sets flag_o and fbf_o at the next edge.
- R9: Any matched operation with io_hc = 1 first acts on the current state, then clears flag_o and fbf_o at the next edge. Op 3 with io_hc = 1 therefore only clears.
- R10: srq_o always equals flag_o.
- R11: A command whose io_dev differs from DEV_SEL changes no state, leaves io_skip at 0 and returns io_din unchanged.
- R12: When an accepted byte and a flag-clearing modifier fall in the same cycle, the byte wins and flag_o ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | A command is present this cycle |
| io_dev | input | 6 | Device field of the command |
| io_op | input | 3 | Operation code (0 none, 1 set ctl, 2 clr ctl, 3 flag, 4 skip-if-clear, 5 skip-if-set, 6 load, 7 merge) |
| io_hc | input | 1 | Hold/clear modifier: clears the flag after the operation |
| io_din | input | 16 | Bus data arriving from the CPU |
| io_dout | output | 16 | Bus data returned to the CPU |
| io_skip | output | 1 | Skip decision for the current command |
| ctl_o | output | 1 | Control flip-flop |
| flag_o | output | 1 | Flag flip-flop |
| fbf_o | output | 1 | Flag buffer flip-flop |
| srq_o | output | 1 | Service request |
| rdr_run | output | 1 | Command flip-flop, drives the reader |
| rdr_start | output | 1 | One-cycle reader start pulse |
| rdr_ready | input | 1 | Byte-ready strobe from the reader |
| rdr_data | input | 8 | Byte from the reader |

## Verification
The data path is tried with two bytes of different bit patterns, 0xA5 and 0x5A. Merge uses bus data whose bits do not overlap the byte, so OR can be told apart from replacement and from pass-through. A second byte is sent while the reader is idle, which shows whether the buffer and the flag are gated by the command flip-flop. Each skip operation is tried against both flag values. The hold/clear modifier is tried on load, on the flag operation and against a byte arriving in the same cycle. Commands aimed at another device number show that the decode keeps foreign traffic away from the state.

// File: rtl/tprd_pkg.sv
package tprd_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_STC   = 3'd1,
      OP_CLC   = 3'd2,
      OP_FLAG  = 3'd3,
      OP_SFC   = 3'd4,
      OP_SFS   = 3'd5,
      OP_LOAD  = 3'd6,
      OP_MERGE = 3'd7
   } tprd_op_e;

   typedef struct packed {
      logic set_ctl;
      logic clr_ctl;
      logic set_flg;
      logic clr_flg;
      logic skip_clr;
      logic skip_set;
      logic load;
      logic merge;
   } tprd_dec_t;
endpackage

// File: rtl/tprd_decode.sv
module tprd_decode
   import tprd_pkg::*;
#(
   parameter int              DEV_W   = 6,
   parameter logic [DEV_W-1:0] DEV_SEL = 6'o10
) (
   input  logic             io_valid,
   input  logic [DEV_W-1:0] io_dev,
   input  logic [2:0]       io_op,
   input  logic             io_hc,
   output tprd_dec_t        dec
);
   logic     hit;
   tprd_op_e op;

   assign hit = io_valid && (io_dev == DEV_SEL);
   assign op  = tprd_op_e'(io_op);

   always_comb begin
      dec          = '0;
      dec.set_ctl  = hit && (op == OP_STC);
      dec.clr_ctl  = hit && (op == OP_CLC);
      dec.set_flg  = hit && (op == OP_FLAG) && !io_hc;
      dec.clr_flg  = hit && io_hc;
      dec.skip_clr = hit && (op == OP_SFC);
      dec.skip_set = hit && (op == OP_SFS);
      dec.load     = hit && (op == OP_LOAD);
      dec.merge    = hit && (op == OP_MERGE);
   end
endmodule

// File: rtl/tprd_ctrl.sv
module tprd_ctrl
   import tprd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  tprd_dec_t dec,
   input  logic      rdr_ready,
   output logic      accept,
   output logic      cmd_q,
   output logic      ctl_q,
   output logic      flag_q,
   output logic      fbf_q,
   output logic      srq_q,
   output logic      start,
   output logic      skip
);
   logic cmd_d, ctl_d, flag_d, fbf_d, cmd_prev;

   assign accept = rdr_ready && cmd_q;

   always_comb begin
      cmd_d = cmd_q;
      if (dec.set_ctl)      cmd_d = 1'b1;
      else if (dec.clr_ctl) cmd_d = 1'b0;
      else if (accept)      cmd_d = 1'b0;

      ctl_d = ctl_q;
      if (dec.set_ctl)      ctl_d = 1'b1;
      else if (dec.clr_ctl) ctl_d = 1'b0;

      flag_d = flag_q;
      fbf_d  = fbf_q;
      if (accept || dec.set_flg) begin
         flag_d = 1'b1;
         fbf_d  = 1'b1;
      end else if (dec.clr_flg) begin
         flag_d = 1'b0;
         fbf_d  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= 1'b0;
         ctl_q    <= 1'b0;
         flag_q   <= 1'b1;
         fbf_q    <= 1'b1;
         srq_q    <= 1'b1;
         cmd_prev <= 1'b0;
      end else begin
         cmd_q    <= cmd_d;
         ctl_q    <= ctl_d;
         flag_q   <= flag_d;
         fbf_q    <= fbf_d;
         srq_q    <= flag_d;
         cmd_prev <= cmd_q;
      end
   end

   assign start = cmd_q && !cmd_prev;
   assign skip  = (dec.skip_set && flag_q) || (dec.skip_clr && !flag_q);
endmodule

// File: rtl/tprd_buf.sv
module tprd_buf #(
   parameter int DATA_W = 8,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] rdr_data,
   input  logic              load,
   input  logic              merge,
   input  logic [BUS_W-1:0]  io_din,
   output logic [BUS_W-1:0]  io_dout
);
   localparam int PAD_W = BUS_W - DATA_W;

   logic [DATA_W-1:0] buf_q;
   logic [BUS_W-1:0]  buf_ext;

   always_ff @(posedge clk) begin
      if (!rst_n)      buf_q <= '0;
      else if (accept) buf_q <= rdr_data;
   end

   generate
      if (PAD_W == 0) begin : g_same
         assign buf_ext = buf_q;
      end else begin : g_pad
         assign buf_ext = {{PAD_W{1'b0}}, buf_q};
      end
   endgenerate

   always_comb begin
      if (load)       io_dout = buf_ext;
      else if (merge) io_dout = io_din | buf_ext;
      else            io_dout = io_din;
   end
endmodule

// File: rtl/tape_rdr_if.sv
module tape_rdr_if
   import tprd_pkg::*;
#(
   parameter int               DEV_W   = 6,
   parameter int               DATA_W  = 8,
   parameter int               BUS_W   = 16,
   parameter logic [DEV_W-1:0] DEV_SEL = 6'o10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_valid,
   input  logic [DEV_W-1:0]  io_dev,
   input  logic [2:0]        io_op,
   input  logic              io_hc,
   input  logic [BUS_W-1:0]  io_din,
   output logic [BUS_W-1:0]  io_dout,
   output logic              io_skip,
   output logic              ctl_o,
   output logic              flag_o,
   output logic              fbf_o,
   output logic              srq_o,
   output logic              rdr_run,
   output logic              rdr_start,
   input  logic              rdr_ready,
   input  logic [DATA_W-1:0] rdr_data
);
   generate
      if (BUS_W < DATA_W) begin : g_bad_width
         $error("tape_rdr_if: BUS_W must be at least DATA_W");
      end
      if (DEV_W < 1) begin : g_bad_dev
         $error("tape_rdr_if: DEV_W must be positive");
      end
   endgenerate

   tprd_dec_t dec;
   logic      accept;

   tprd_decode #(.DEV_W(DEV_W), .DEV_SEL(DEV_SEL)) i_decode (
      .io_valid (io_valid),
      .io_dev   (io_dev),
      .io_op    (io_op),
      .io_hc    (io_hc),
      .dec      (dec)
   );

   tprd_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec       (dec),
      .rdr_ready (rdr_ready),
      .accept    (accept),
      .cmd_q     (rdr_run),
      .ctl_q     (ctl_o),
      .flag_q    (flag_o),
      .fbf_q     (fbf_o),
      .srq_q     (srq_o),
      .start     (rdr_start),
      .skip      (io_skip)
   );

   tprd_buf #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .rdr_data (rdr_data),
      .load     (dec.load),
      .merge    (dec.merge),
      .io_din   (io_din),
      .io_dout  (io_dout)
   );
endmodule

// File: rtl/tprd_chk.sv
module tprd_chk #(
   parameter int               DEV_W   = 6,
   parameter int               DATA_W  = 8,
   parameter int               BUS_W   = 16,
   parameter logic [DEV_W-1:0] DEV_SEL = 6'o10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_valid,
   input logic [DEV_W-1:0]  io_dev,
   input logic [2:0]        io_op,
   input logic              io_hc,
   input logic [BUS_W-1:0]  io_din,
   input logic [BUS_W-1:0]  io_dout,
   input logic              io_skip,
   input logic              ctl_o,
   input logic              flag_o,
   input logic              fbf_o,
   input logic              srq_o,
   input logic              rdr_run,
   input logic              rdr_start,
   input logic              rdr_ready,
   input logic [DATA_W-1:0] rdr_data
);
   logic hit;
   assign hit = io_valid && (io_dev == DEV_SEL);

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rdr_start |=> !rdr_start); // R2
   AST_STC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && io_op == 3'd1) |=> (ctl_o && rdr_run)); // R2
   AST_CLC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && io_op == 3'd2) |=> (!ctl_o && !rdr_run)); // R3
   AST_BYTE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (rdr_run && rdr_ready && !(hit && io_op == 3'd1)) |=> (flag_o && fbf_o && !rdr_run)); // R4
   AST_SKIP_ONLY_ON_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      io_skip |-> (hit && (io_op == 3'd4 || io_op == 3'd5))); // R7
   AST_SRQ_TRACKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      srq_o == flag_o); // R10
   AST_FOREIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && io_dev != DEV_SEL) |-> (io_dout == io_din && !io_skip)); // R11
   AST_HC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && io_hc && !(rdr_run && rdr_ready)) |=> (!flag_o && !fbf_o)); // R9
endmodule

bind tape_rdr_if tprd_chk #(
   .DEV_W(DEV_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .DEV_SEL(DEV_SEL)
) i_tprd_chk (
   .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_dev(io_dev),
   .io_op(io_op), .io_hc(io_hc), .io_din(io_din), .io_dout(io_dout),
   .io_skip(io_skip), .ctl_o(ctl_o), .flag_o(flag_o), .fbf_o(fbf_o),
   .srq_o(srq_o), .rdr_run(rdr_run), .rdr_start(rdr_start),
   .rdr_ready(rdr_ready), .rdr_data(rdr_data)
);

// File: tb/test_tape_rdr_if.sv
`timescale 1ns/1ps
module test_tape_rdr_if;
   localparam logic [5:0] MY_DEV = 6'o10;
   localparam logic [5:0] OTHER  = 6'o11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_valid = 1'b0;
   logic [5:0]  io_dev = '0;
   logic [2:0]  io_op = '0;
   logic        io_hc = 1'b0;
   logic [15:0] io_din = '0;
   logic [15:0] io_dout;
   logic        io_skip, ctl_o, flag_o, fbf_o, srq_o, rdr_run, rdr_start;
   logic        rdr_ready = 1'b0;
   logic [7:0]  rdr_data = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] got_dout;
   logic        got_skip;

   always #2.5 clk = ~clk;

   tape_rdr_if #(.DEV_SEL(MY_DEV)) i_tape_rdr_if (
      .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_dev(io_dev),
      .io_op(io_op), .io_hc(io_hc), .io_din(io_din), .io_dout(io_dout),
      .io_skip(io_skip), .ctl_o(ctl_o), .flag_o(flag_o), .fbf_o(fbf_o),
      .srq_o(srq_o), .rdr_run(rdr_run), .rdr_start(rdr_start),
      .rdr_ready(rdr_ready), .rdr_data(rdr_data)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // drive a command at a negedge, capture combinational results, end at next negedge
   task automatic issue(input logic [2:0] op, input logic hc, input logic [5:0] dev,
                        input logic [15:0] din);
      io_valid = 1'b1; io_op = op; io_hc = hc; io_dev = dev; io_din = din;
      #1;
      got_dout = io_dout; got_skip = io_skip;
      @(negedge clk);
      io_valid = 1'b0; io_op = 3'd0; io_hc = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      rdr_ready = 1'b1; rdr_data = b;
      @(negedge clk);
      rdr_ready = 1'b0;
   endtask

   task automatic t_reset;
      check({15'd0, ctl_o}, 16'd0, "R1 ctl after reset");
      check({15'd0, rdr_run}, 16'd0, "R1 run after reset");
      check({13'd0, flag_o, fbf_o, srq_o}, 16'd7, "R1 flag/fbf/srq after reset");
      check({15'd0, rdr_start}, 16'd0, "R1 no start after reset");
      issue(3'd6, 1'b0, MY_DEV, 16'hFFFF);
      check(got_dout, 16'h0000, "R1 load returns zero buffer");
   endtask

   task automatic t_flag_ops;
      issue(3'd5, 1'b0, MY_DEV, 16'h0);
      check({15'd0, got_skip}, 16'd1, "R7 skip-if-set with flag 1");
      issue(3'd4, 1'b0, MY_DEV, 16'h0);
      check({15'd0, got_skip}, 16'd0, "R7 skip-if-clear with flag 1");
      issue(3'd3, 1'b1, MY_DEV, 16'h0);
      check({14'd0, flag_o, fbf_o}, 16'd0, "R9 flag op with modifier clears");
      check({15'd0, srq_o}, 16'd0, "R10 srq follows cleared flag");
      issue(3'd4, 1'b0, MY_DEV, 16'h0);
      check({15'd0, got_skip}, 16'd1, "R7 skip-if-clear with flag 0");
      issue(3'd5, 1'b0, MY_DEV, 16'h0);
      check({15'd0, got_skip}, 16'd0, "R7 skip-if-set with flag 0");
      issue(3'd6, 1'b0, MY_DEV, 16'h0);
      check({15'd0, got_skip}, 16'd0, "R7 load never skips");
      issue(3'd3, 1'b0, MY_DEV, 16'h0);
      check({14'd0, flag_o, fbf_o}, 16'd3, "R8 set flag");
      check({15'd0, srq_o}, 16'd1, "R10 srq follows set flag");
      issue(3'd3, 1'b1, MY_DEV, 16'h0);
   endtask

   task automatic t_read_cycle;
      issue(3'd1, 1'b0, MY_DEV, 16'h0);
      check({14'd0, ctl_o, rdr_run}, 16'd3, "R2 set control sets ctl and run");
      check({15'd0, rdr_start}, 16'd1, "R2 start pulse after run rises");
      @(negedge clk);
      check({15'd0, rdr_start}, 16'd0, "R2 start pulse one cycle");
      send_byte(8'hA5);
      check({15'd0, rdr_run}, 16'd0, "R4 byte clears run");
      check({14'd0, flag_o, fbf_o}, 16'd3, "R4 byte sets flag and fbf");
      check({15'd0, ctl_o}, 16'd1, "R4 ctl unaffected by byte");
      issue(3'd6, 1'b0, MY_DEV, 16'hFF00);
      check(got_dout, 16'h00A5, "R6 load returns byte");
      issue(3'd7, 1'b0, MY_DEV, 16'h1200);
      check(got_dout, 16'h12A5, "R6 merge ORs byte");
      issue(3'd5, 1'b0, MY_DEV, 16'h3456);
      check(got_dout, 16'h3456, "R6 other op passes bus data");
      issue(3'd6, 1'b1, MY_DEV, 16'h0);
      check(got_dout, 16'h00A5, "R9 load with modifier still reads");
      check({14'd0, flag_o, fbf_o}, 16'd0, "R9 load with modifier clears flag");
   endtask

   task automatic t_restart_and_stop;
      issue(3'd1, 1'b0, MY_DEV, 16'h0);
      issue(3'd1, 1'b0, MY_DEV, 16'h0);
      check({15'd0, rdr_start}, 16'd0, "R2 no pulse when already running");
      issue(3'd2, 1'b0, MY_DEV, 16'h0);
      check({14'd0, ctl_o, rdr_run}, 16'd0, "R3 clear control clears ctl and run");
   endtask

   task automatic t_idle_byte;
      send_byte(8'h3C);
      check({15'd0, flag_o}, 16'd0, "R5 idle byte leaves flag");
      issue(3'd6, 1'b0, MY_DEV, 16'h0);
      check(got_dout, 16'h00A5, "R5 idle byte leaves buffer");
   endtask

   task automatic t_foreign;
      issue(3'd1, 1'b0, OTHER, 16'h0);
      check({14'd0, ctl_o, rdr_run}, 16'd0, "R11 foreign set control ignored");
      issue(3'd4, 1'b0, OTHER, 16'h0);
      check({15'd0, got_skip}, 16'd0, "R11 foreign skip ignored");
      issue(3'd6, 1'b0, OTHER, 16'hBEEF);
      check(got_dout, 16'hBEEF, "R11 foreign load passes bus data");
      issue(3'd3, 1'b0, OTHER, 16'h0);
      check({15'd0, flag_o}, 16'd0, "R11 foreign set flag ignored");
   endtask

   task automatic t_collision;
      issue(3'd1, 1'b0, MY_DEV, 16'h0);
      io_valid = 1'b1; io_op = 3'd3; io_hc = 1'b1; io_dev = MY_DEV;
      rdr_ready = 1'b1; rdr_data = 8'h5A;
      @(negedge clk);
      io_valid = 1'b0; io_op = 3'd0; io_hc = 1'b0; rdr_ready = 1'b0;
      check({15'd0, flag_o}, 16'd1, "R12 byte beats flag clear");
      check({15'd0, rdr_run}, 16'd0, "R12 run cleared by byte");
      issue(3'd6, 1'b0, MY_DEV, 16'h0);
      check(got_dout, 16'h005A, "R12 buffer holds byte");
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flag_ops();
      t_read_cycle();
      t_restart_and_stop();
      t_idle_byte();
      t_foreign();
      t_collision();
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule